// File: doc/BRIEF.md
# Eight-Channel Extended Match Timer

The block holds eight match channels, numbered 4 to 11 and held internally as indices 0 to 7. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word chooses which tick enable advances the counter. It also chooses whether the channel compares against its own counter or against a counter shared by its group: channels 4–7 share counter 4, channels 8–9 share counter 8, and channels 10–11 share counter 10. Further control bits decide whether a match zeroes the counter, whether the channel keeps matching on later passes, and whether reading its counter captures the paired counter into a snapshot register. The tick enables come from outside the block. Each is a single-cycle pulse that stands for one period of its clock.

When a channel's compared counter steps onto the channel's match value, the channel raises a match for that cycle. If the channel's interrupt-enable bit is set, the match also sets the channel's status bit. One interrupt output stays high while any status bit is set. Software clears status bits by writing ones to them.

Each channel is run by a two-state machine. CH_ARMED means the channel may match. CH_SPENT means a one-shot channel has already fired. The transition FIRE goes from CH_ARMED to CH_SPENT on a match when periodic mode is off. The transition REARM goes from either state to CH_ARMED when software writes the channel's match or control register. With periodic mode on, a match leaves the channel in CH_ARMED.

Top module: `xmatch_timer`

## Requirements
- R1: After reset, every counter, match, control, enable, status and snapshot register reads zero and irq_o is low.
- R2: Control bits [2:0] pick the counter's tick: 1 uses tick_i[0] (32.768 kHz), 2 uses tick_i[1] (1 kHz), 3 uses tick_i[2] (1 Hz) and 4 uses tick_i[3] (1 MHz). The codes 0, 5, 6 and 7 leave the counter stopped.
- R3: With control bit 7 set, a channel advances and compares its own counter. With bit 7 clear, it compares against its group's shared counter (counter 4, 8 or 10).
- R4: A channel that is not a group owner (channels 5–7, 9 and 11) and has control bit 7 clear does not advance its own counter.
- R5: Control registers of channels 4–7 keep bits [7:0]. Those of channels 8–11 keep bits [9:0]. On channels 8–11, bit 8 set stops the counter.
- R6: With control bit 3 set, a match loads zero into the compared counter in place of the match value.
- R7: With control bit 6 clear, a channel matches once (CH_ARMED to CH_SPENT) until its match or control register is written again. With bit 6 set, it matches on every pass.
- R8: A read of counter 9 or 11 while that channel's control bit 9 is set copies counter 8 or counter 10 into the snapshot register at 0x20. Without bit 9 set, the snapshot register is left unchanged.
- R9: A match sets status bit k+4 (register 0x14) only when enable bit k+4 (register 0x1C) is set.
- R10: irq_o is high while any of status bits [11:4] is set. Writing ones to 0x14 clears those bits, and irq_o falls once none is left.
- R11: A counter is 32 bits wide, wraps from all ones to zero, and loads the written value on a write. A control write does not change the counter value.
- R12: Registers sit at these byte addresses: counters at 0x40+4k, match values at 0x80+4k, control words at 0xC0+4k (k = channel−4), status at 0x14, enables at 0x1C and snapshot at 0x20. Read data appears one cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous) |
| tick_i | input | 4 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Combined match interrupt |

## Verification
The counter path is driven by pulsing one tick line at a time under several clock-select codes. This shows that only the selected tick advances the counter, and that a stopped code holds the count through pulses on every line. Match tests use several channels that share one counter but differ in enable, periodic and reset-on-match settings. These separate a match that sets status from one that is masked, a one-shot channel from a periodic one, and a clearing match from a plain one. The snapshot test reads the pairing counter with the capture bit set and again with it clear, so a capture is told apart from a stale value. The group routing is tried once with bit 7 clear and once with it set, to show which counter each setting advances.

// File: rtl/xm_pkg.sv
package xm_pkg;
    localparam int NCH   = 8;
    localparam int CTL_W = 10;
    localparam int NTICK = 4;

    // control bit positions
    localparam int CB_CLR  = 3;
    localparam int CB_PER  = 6;
    localparam int CB_OWN  = 7;
    localparam int CB_HALT = 8;
    localparam int CB_SNAP = 9;

    typedef enum logic {CH_ARMED, CH_SPENT} ch_state_e;

    // index of the counter a channel shares when it does not use its own
    function automatic int owner_of(input int k);
        if (k < 4) return 0;
        else if (k < 6) return 4;
        else return 6;
    endfunction
endpackage

// File: rtl/xm_counter.sv
module xm_counter
    import xm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit IS_OWNER = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sel_i,
    input  logic             own_i,
    input  logic             halt_i,
    input  logic [NTICK-1:0] tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             step_o
);
    logic src_tick;

    always_comb begin
        unique case (sel_i)
            3'd1:    src_tick = tick_i[0];
            3'd2:    src_tick = tick_i[1];
            3'd3:    src_tick = tick_i[2];
            3'd4:    src_tick = tick_i[3];
            default: src_tick = 1'b0;
        endcase
    end

    assign step_o = src_tick && !halt_i && (IS_OWNER || own_i);
    assign nxt_o  = cnt_o + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (clr_i)  cnt_o <= '0;
        else if (step_o) cnt_o <= nxt_o;
    end

    // R11: an undisturbed step moves the count by exactly one, wrapping
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !load_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R2: with no step, load or clear the count holds
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_o && !load_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/xm_channel.sv
module xm_channel
    import xm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periodic_i,
    input  logic             rearm_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic [CNT_W-1:0] match_i,
    output logic             hit_o
);
    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        hit_o   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            CH_ARMED: begin
                hit_o = step_i && (nxt_i == match_i);
                if (rearm_i)                  state_d = CH_ARMED;
                else if (hit_o && !periodic_i) state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (rearm_i) state_d = CH_ARMED;
            end
            default: state_d = CH_ARMED;
        endcase
    end

    // R7: a one-shot channel never matches in two successive cycles without a rearm
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !periodic_i && !rearm_i) |=> !hit_o);

    // R7: a register write always leaves the channel able to match
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (state_q == CH_ARMED));
endmodule

// File: rtl/xmatch_timer.sv
module xmatch_timer
    import xm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTICK-1:0]  tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam logic [2:0]        RG_CNT = 3'b010;
    localparam logic [2:0]        RG_MAT = 3'b100;
    localparam logic [2:0]        RG_CTL = 3'b110;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] A_SNAP = ADDR_W'(8'h20);

    logic [CTL_W-1:0] ctl_q   [NCH];
    logic [CNT_W-1:0] match_q [NCH];
    logic [CNT_W-1:0] cnt     [NCH];
    logic [CNT_W-1:0] nxt     [NCH];
    logic [CNT_W-1:0] nxt_sel [NCH];
    logic [NCH-1:0]   step, step_sel, hit, clr, load, rearm;
    logic [NCH-1:0]   ie_q, st_q;
    logic [CNT_W-1:0] snap_q, rd_val;

    logic       aligned, st_wr, snap_take;
    logic [2:0] region, ri;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign region  = addr_i[7:5];
    assign ri      = addr_i[4:2];
    assign st_wr   = wr_en_i && aligned && (addr_i == A_STAT);

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_ch
            localparam int                OWN  = owner_of(k);
            localparam logic [CTL_W-1:0]  MASK = (k >= 4) ? CTL_W'(10'h3FF) : CTL_W'(10'h0FF);
            logic ctl_wr, mat_wr;

            assign ctl_wr   = wr_en_i && aligned && (region == RG_CTL) && (ri == 3'(k));
            assign mat_wr   = wr_en_i && aligned && (region == RG_MAT) && (ri == 3'(k));
            assign load[k]  = wr_en_i && aligned && (region == RG_CNT) && (ri == 3'(k));
            assign rearm[k] = ctl_wr || mat_wr;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctl_q[k]   <= '0;
                    match_q[k] <= '0;
                end else begin
                    if (ctl_wr) ctl_q[k]   <= wdata_i[CTL_W-1:0] & MASK;
                    if (mat_wr) match_q[k] <= wdata_i;
                end
            end

            xm_counter #(.CNT_W(CNT_W), .IS_OWNER(OWN == k)) u_cnt (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel_i      (ctl_q[k][2:0]),
                .own_i      (ctl_q[k][CB_OWN]),
                .halt_i     (ctl_q[k][CB_HALT]),
                .tick_i     (tick_i),
                .load_i     (load[k]),
                .load_val_i (wdata_i),
                .clr_i      (clr[k]),
                .cnt_o      (cnt[k]),
                .nxt_o      (nxt[k]),
                .step_o     (step[k])
            );

            assign step_sel[k] = ctl_q[k][CB_OWN] ? step[k] : step[OWN];
            assign nxt_sel[k]  = ctl_q[k][CB_OWN] ? nxt[k]  : nxt[OWN];

            xm_channel #(.CNT_W(CNT_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .periodic_i (ctl_q[k][CB_PER]),
                .rearm_i    (rearm[k]),
                .step_i     (step_sel[k]),
                .nxt_i      (nxt_sel[k]),
                .match_i    (match_q[k]),
                .hit_o      (hit[k])
            );
        end
    endgenerate

    // zero the compared counter of any clearing channel that matched
    always_comb begin
        clr = '0;
        for (int j = 0; j < NCH; j++) begin
            if (hit[j] && ctl_q[j][CB_CLR]) begin
                if (ctl_q[j][CB_OWN]) clr[j] = 1'b1;
                else                  clr[owner_of(j)] = 1'b1;
            end
        end
    end

    assign snap_take = rd_en_i && aligned && (region == RG_CNT) &&
                       ((ri == 3'd5) || (ri == 3'd7)) && ctl_q[ri][CB_SNAP];

    always_comb begin
        rd_val = '0;
        if (aligned) begin
            unique case (region)
                RG_CNT:  rd_val = cnt[ri];
                RG_MAT:  rd_val = match_q[ri];
                RG_CTL:  rd_val = CNT_W'(ctl_q[ri]);
                default: begin
                    if (addr_i == A_STAT)      rd_val = CNT_W'({st_q, 4'b0000});
                    else if (addr_i == A_IE)   rd_val = CNT_W'({ie_q, 4'b0000});
                    else if (addr_i == A_SNAP) rd_val = snap_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= '0;
            st_q    <= '0;
            snap_q  <= '0;
            rdata_o <= '0;
        end else begin
            if (wr_en_i && aligned && (addr_i == A_IE)) ie_q <= wdata_i[11:4];
            st_q <= (st_q & ~(st_wr ? wdata_i[11:4] : '0)) | (hit & ie_q);
            if (snap_take) snap_q <= cnt[3'(ri - 3'd1)];
            if (rd_en_i) rdata_o <= rd_val;
        end
    end

    assign irq_o = |st_q;

    // R9: a status bit only appears for a channel whose enable was set
    assert_status_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(ie_q)) == '0));

    // R10: the interrupt drops only after a status write
    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(st_wr));

    // R8: the snapshot changes only after a capturing read
    assert_snap_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_q) |-> $past(snap_take));

    // R5: channels 4..7 never hold the upper control bits
    assert_ctl_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0][9:8] == 2'b00) && (ctl_q[1][9:8] == 2'b00) &&
        (ctl_q[2][9:8] == 2'b00) && (ctl_q[3][9:8] == 2'b00));
endmodule

// File: tb/sim_xmatch_timer.sv
`timescale 1ns/1ps
module sim_xmatch_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    xmatch_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compare each read result against the queued expectation
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tk(input int b, input int n);
        @(negedge clk); tick[b] = 1'b1;
        repeat (n) @(negedge clk);
        tick = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h40, 32'h0, "R1 counter4");
        rd(8'h20, 32'h0, "R1 snapshot");
        rd(8'h14, 32'h0, "R1 status");
        rd(8'hC0, 32'h0, "R1 control4");
        chk_irq(1'b0, "R1 irq");
        // R2 clock select
        wr(8'hC0, 32'h4);
        tk(3, 5);
        rd(8'h40, 32'd5, "R2 1MHz tick");
        tk(0, 3);
        rd(8'h40, 32'd5, "R2 unselected tick");
        wr(8'hC0, 32'h1);
        rd(8'h40, 32'd5, "R11 control write keeps count");
        tk(0, 3);
        rd(8'h40, 32'd8, "R2 32k tick");
        wr(8'hC0, 32'h5);
        tk(3, 2); tk(0, 2); tk(1, 2); tk(2, 2);
        rd(8'h40, 32'd8, "R2 code 5 stopped");
        // R4 / R3 sharing
        wr(8'hC0, 32'h4);
        wr(8'hC4, 32'h4);
        wr(8'h44, 32'd100);
        tk(3, 3);
        rd(8'h44, 32'd100, "R4 non-owner holds");
        rd(8'h40, 32'd11, "R3 shared counter runs");
        wr(8'hC4, 32'h84);
        tk(3, 2);
        rd(8'h44, 32'd102, "R3 own counter runs");
        rd(8'h40, 32'd13, "R3 shared also runs");
        // R9 / R10 matching on the shared counter
        wr(8'h1C, 32'hA0);
        wr(8'hC4, 32'h0);
        wr(8'h84, 32'd3);
        wr(8'h88, 32'd2);
        wr(8'h8C, 32'd3);
        wr(8'h40, 32'd0);
        tk(3, 3);
        rd(8'h14, 32'hA0, "R9 enabled bits only");
        chk_irq(1'b1, "R10 irq high");
        wr(8'h14, 32'h20);
        rd(8'h14, 32'h80, "R10 partial clear");
        chk_irq(1'b1, "R10 irq still high");
        wr(8'h14, 32'h80);
        rd(8'h14, 32'h0, "R10 full clear");
        chk_irq(1'b0, "R10 irq low");
        // R7 one-shot and periodic
        wr(8'h40, 32'd0);
        tk(3, 3);
        rd(8'h14, 32'h0, "R7 one-shot spent");
        wr(8'hCC, 32'h40);
        wr(8'h40, 32'd0);
        tk(3, 3);
        rd(8'h14, 32'h80, "R7 periodic first");
        wr(8'h14, 32'h80);
        wr(8'h40, 32'd0);
        tk(3, 3);
        rd(8'h14, 32'h80, "R7 periodic again");
        wr(8'h14, 32'h80);
        wr(8'h84, 32'd3);
        wr(8'h40, 32'd0);
        tk(3, 3);
        rd(8'h14, 32'hA0, "R7 rearm by match write");
        wr(8'h14, 32'hA0);
        wr(8'hC0, 32'h0);
        // R6 reset on match
        wr(8'h1C, 32'h1A0);
        wr(8'hD0, 32'h4C);
        wr(8'h90, 32'd4);
        wr(8'h50, 32'd0);
        tk(3, 4);
        rd(8'h50, 32'd0, "R6 cleared on match");
        rd(8'h14, 32'h100, "R6 match flagged");
        tk(3, 2);
        rd(8'h50, 32'd2, "R6 counts after clear");
        tk(3, 2);
        rd(8'h50, 32'd0, "R6 cleared again");
        wr(8'h14, 32'h100);
        // R5 masks and halt
        wr(8'hD0, 32'h14C);
        tk(3, 3);
        rd(8'h50, 32'd0, "R5 bit8 halts");
        rd(8'hD0, 32'h14C, "R5 wide control");
        wr(8'hC0, 32'h3FF);
        rd(8'hC0, 32'hFF, "R5 narrow control");
        wr(8'hD4, 32'h3FF);
        rd(8'hD4, 32'h3FF, "R5 wide control 9");
        wr(8'hC0, 32'h0);
        // R8 snapshot
        wr(8'hD0, 32'h4);
        wr(8'h50, 32'h1234);
        wr(8'hD4, 32'h200);
        rd(8'h54, 32'h0, "R8 counter9 read");
        rd(8'h20, 32'h1234, "R8 captured");
        wr(8'hD4, 32'h0);
        wr(8'h50, 32'h55);
        rd(8'h54, 32'h0, "R8 counter9 read plain");
        rd(8'h20, 32'h1234, "R8 no capture");
        // R11 wrap
        wr(8'hC0, 32'h4);
        wr(8'h40, 32'hFFFF_FFFF);
        tk(3, 1);
        rd(8'h40, 32'h0, "R11 wrap");
        // R12 map
        rd(8'h88, 32'd2, "R12 match6 readback");
        rd(8'h1C, 32'h1A0, "R12 enable readback");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule